// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a bus master and a byte-addressed backing memory. It gives software a large alias window in which every 32-bit word stands for one bit of a much smaller backing region. Reading an alias word returns the value of that single bit. Writing an alias word sets or clears that bit and leaves every other bit of the backing memory unchanged.

A request carries an offset into the alias window, an access size and write data. The bridge turns the offset into a backing byte address and a bit position. It then issues one backing read, or a read followed by a write of the same size to the same address. A sequencer runs each request to completion before it takes the next one, so a read-modify-write is never split by another alias access. Backing errors, and access sizes the bridge cannot handle, come back as an error response.

A system normally places two copies side by side, one with its base at 0x2000_0000 and one with its base at 0x4000_0000. The base is a parameter.

Top module: `bitband_bridge`

## Requirements
- R1: The backing address is BASE OR (offset[24:0] >> 5), with its low bits cleared to a multiple of the access size. Offset bits 31:25 are ignored.
- R2: The size code is 0 for one byte, 1 for two bytes and 2 for four bytes. The backing access uses the same size code as the alias request.
- R3: The bit index is offset[6:2] masked with (8 x bytes − 1). Backing data is right-justified and little-endian: the byte at the backing address is in bits 7:0, so the target bit is data bit [index].
- R4: An alias read makes exactly one backing read. It returns the selected bit in rsp_rdata_o[0], and bits 31:1 are zero.
- R5: An alias write reads the backing data and then writes it back to the same address with the same size. The target bit is set when req_wdata_i[0] is 1 and cleared when it is 0. Every other backing bit and req_wdata_i[31:1] have no effect.
- R6: An error on the backing read gives rsp_err_o = 1 and rsp_rdata_o = 0. For an alias write it also suppresses the backing write.
- R7: An error on the backing write is returned as rsp_err_o = 1.
- R8: Size code 3 is illegal. It gets an error response, and no backing access is made.
- R9: req_ready_o stays low from the acceptance of a request until its response has been taken (rsp_valid_o and rsp_ready_i both high). rsp_valid_o, rsp_rdata_o and rsp_err_o hold steady while rsp_ready_i is low.
- R10: During reset, req_ready_o is 1 and rsp_valid_o and mem_valid_o are 0.
- R11: mem_valid_o, mem_addr_o, mem_size_o, mem_write_o and mem_wdata_o hold steady until mem_ready_i completes the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Alias request valid |
| req_ready_o | output | 1 | Bridge can accept a request |
| req_write_i | input | 1 | 1 = alias write, 0 = alias read |
| req_addr_i | input | 32 | Byte offset into the alias window |
| req_size_i | input | 2 | Access size code (0/1/2; 3 is illegal) |
| req_wdata_i | input | 32 | Write data; only bit 0 is used |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response accepted |
| rsp_rdata_o | output | 32 | Selected bit in bit 0, zeros above |
| rsp_err_o | output | 1 | Error response |
| mem_valid_o | output | 1 | Backing access request |
| mem_write_o | output | 1 | Backing access is a write |
| mem_addr_o | output | 32 | Backing byte address |
| mem_size_o | output | 2 | Backing access size code |
| mem_wdata_o | output | 32 | Backing write data, right-justified |
| mem_ready_i | input | 1 | Backing access completes this cycle |
| mem_rdata_i | input | 32 | Backing read data, right-justified |
| mem_err_i | input | 1 | Backing access error, valid with mem_ready_i |

## Verification
The hardest case to reach is a backing error that hits the read half of an alias write. At the ports it shows only as a missing write and an error flag. The bench memory responder can be armed to fail a read, or a write, at one chosen byte address. The bench counts backing writes around the request and compares the memory contents before and after. A second hard case is back-pressure at both ends. The responder adds wait cycles, and the bench holds rsp_ready_i low for several cycles, while it checks that req_ready_o stays low and that the outputs do not move.

// File: rtl/bitband_pkg.sv
package bitband_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RESP  = 2'd3
  } seq_state_e;

  function automatic logic [4:0] bit_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: bit_mask = 5'd7;
      SZ_HALF: bit_mask = 5'd15;
      default: bit_mask = 5'd31;
    endcase
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_mask = 32'h0000_00FF;
      SZ_HALF: lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/bb_xlate.sv
module bb_xlate
  import bitband_pkg::*;
#(
  parameter logic [31:0] BASE     = 32'h2000_0000,
  parameter int unsigned WIN_BITS = 25,
  parameter int unsigned AW       = 32
) (
  input  logic [AW-1:0] offset_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [4:0]    bit_idx_o,
  output logic          size_ok_o
);
  localparam int unsigned BYTE_BITS = WIN_BITS - 5;

  logic [AW-1:0] raw_addr;
  logic [AW-1:0] align_clr;

  assign raw_addr = BASE | {{(AW-BYTE_BITS){1'b0}}, offset_i[WIN_BITS-1:5]};

  always_comb begin
    case (size_i)
      SZ_BYTE: align_clr = '0;
      SZ_HALF: align_clr = AW'(1);
      default: align_clr = AW'(3);
    endcase
  end

  assign mem_addr_o = raw_addr & ~align_clr;
  assign bit_idx_o  = offset_i[6:2] & bit_mask(size_i);
  assign size_ok_o  = (size_i != SZ_BAD);

  logic unused_hi;
  assign unused_hi = ^{offset_i[AW-1:WIN_BITS], offset_i[1:0]};
endmodule

// File: rtl/bb_bitop.sv
module bb_bitop
  import bitband_pkg::*;
(
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    size_i,
  input  logic [4:0]    bit_idx_i,
  input  logic          set_i,
  output logic          bit_o,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] clean;
  logic [DW-1:0] onehot;

  assign clean  = data_i & lane_mask(size_i);
  assign onehot = DW'(1) << bit_idx_i;
  assign bit_o  = clean[bit_idx_i];
  assign data_o = set_i ? (clean | onehot) : (clean & ~onehot);
endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bitband_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       size_ok_i,
  input  logic       write_q_i,
  input  logic       mem_ready_i,
  input  logic       mem_err_i,
  input  logic       rsp_ready_i,
  output seq_state_e state_o,
  output logic       accept_o,
  output logic       rd_done_o,
  output logic       wr_done_o
);
  seq_state_e state_q, state_d;

  assign accept_o  = (state_q == ST_IDLE) && req_valid_i;
  assign rd_done_o = (state_q == ST_READ) && mem_ready_i;
  assign wr_done_o = (state_q == ST_WRITE) && mem_ready_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = size_ok_i ? ST_READ : ST_RESP;
      ST_READ:  if (mem_ready_i) state_d = (write_q_i && !mem_err_i) ? ST_WRITE : ST_RESP;
      ST_WRITE: if (mem_ready_i) state_d = ST_RESP;
      ST_RESP:  if (rsp_ready_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bitband_pkg::*;
#(
  parameter logic [31:0] BASE     = 32'h2000_0000,
  parameter int unsigned WIN_BITS = 25
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [31:0] req_addr_i,
  input  logic [1:0]  req_size_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  input  logic        rsp_ready_i,
  output logic [31:0] rsp_rdata_o,
  output logic        rsp_err_o,
  output logic        mem_valid_o,
  output logic        mem_write_o,
  output logic [31:0] mem_addr_o,
  output logic [1:0]  mem_size_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ready_i,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_err_i
);
  seq_state_e state;
  logic       accept, rd_done, wr_done;

  logic [31:0] xl_addr;
  logic [4:0]  xl_bit;
  logic        xl_ok;

  logic [31:0] addr_q;
  logic [1:0]  size_q;
  logic [4:0]  bit_q;
  logic        write_q;
  logic        set_q;
  logic [31:0] wdata_q;
  logic        rbit_q;
  logic        err_q;

  logic        sel_bit;
  logic [31:0] mod_data;

  bb_xlate #(
    .BASE    (BASE),
    .WIN_BITS(WIN_BITS),
    .AW      (32)
  ) u_xlate (
    .offset_i  (req_addr_i),
    .size_i    (req_size_i),
    .mem_addr_o(xl_addr),
    .bit_idx_o (xl_bit),
    .size_ok_o (xl_ok)
  );

  bb_bitop u_bitop (
    .data_i   (mem_rdata_i),
    .size_i   (size_q),
    .bit_idx_i(bit_q),
    .set_i    (set_q),
    .bit_o    (sel_bit),
    .data_o   (mod_data)
  );

  bb_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .size_ok_i  (xl_ok),
    .write_q_i  (write_q),
    .mem_ready_i(mem_ready_i),
    .mem_err_i  (mem_err_i),
    .rsp_ready_i(rsp_ready_i),
    .state_o    (state),
    .accept_o   (accept),
    .rd_done_o  (rd_done),
    .wr_done_o  (wr_done)
  );

  // request capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      size_q  <= SZ_BYTE;
      bit_q   <= '0;
      write_q <= 1'b0;
      set_q   <= 1'b0;
    end else if (accept) begin
      addr_q  <= xl_addr;
      size_q  <= req_size_i;
      bit_q   <= xl_bit;
      write_q <= req_write_i;
      set_q   <= req_wdata_i[0];
    end
  end

  // data path and status
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
      rbit_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (accept) begin
        rbit_q <= 1'b0;
        err_q  <= !xl_ok;
      end
      if (rd_done) begin
        wdata_q <= mod_data;
        rbit_q  <= !write_q && !mem_err_i && sel_bit;
        err_q   <= mem_err_i;
      end
      if (wr_done) err_q <= mem_err_i;
    end
  end

  assign req_ready_o = (state == ST_IDLE);
  assign rsp_valid_o = (state == ST_RESP);
  assign rsp_rdata_o = {31'b0, rbit_q};
  assign rsp_err_o   = err_q;

  assign mem_valid_o = (state == ST_READ) || (state == ST_WRITE);
  assign mem_write_o = (state == ST_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_size_o  = size_q;
  assign mem_wdata_o = (state == ST_WRITE) ? wdata_q : '0;

  logic unused_wd;
  assign unused_wd = ^req_wdata_i[31:1];
endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        req_write_i,
  input logic [31:0] req_addr_i,
  input logic [1:0]  req_size_i,
  input logic [31:0] req_wdata_i,
  input logic        rsp_valid_o,
  input logic        rsp_ready_i,
  input logic [31:0] rsp_rdata_o,
  input logic        rsp_err_o,
  input logic        mem_valid_o,
  input logic        mem_write_o,
  input logic [31:0] mem_addr_o,
  input logic [1:0]  mem_size_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_ready_i,
  input logic [31:0] mem_rdata_i,
  input logic        mem_err_i
);
  logic        rd_err_seen;
  logic        have_rd;
  logic [31:0] last_rd_addr;
  logic [1:0]  last_rd_size;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_err_seen  <= 1'b0;
      have_rd      <= 1'b0;
      last_rd_addr <= '0;
      last_rd_size <= '0;
    end else begin
      if (mem_valid_o && !mem_write_o && mem_ready_i) begin
        have_rd      <= 1'b1;
        last_rd_addr <= mem_addr_o;
        last_rd_size <= mem_size_o;
        rd_err_seen  <= mem_err_i;
      end else if (rsp_valid_o && rsp_ready_i) begin
        have_rd     <= 1'b0;
        rd_err_seen <= 1'b0;
      end
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R10: assert (req_ready_o && !rsp_valid_o && !mem_valid_o)
        else $error("R10 outputs not idle in reset");
    end
  end

  assert_align_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> ((mem_size_o == 2'd2) ? (mem_addr_o[1:0] == 2'b00) :
                     (mem_size_o == 2'd1) ? (mem_addr_o[0] == 1'b0) : 1'b1));

  assert_legal_size_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_size_o != 2'd3));

  assert_rdata_format_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_rdata_o[31:1] == 31'b0));

  assert_wr_same_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_write_o) |-> (have_rd && mem_addr_o == last_rd_addr &&
                                      mem_size_o == last_rd_size));

  assert_rderr_nowrite_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_seen |-> !(mem_valid_o && mem_write_o));

  assert_rderr_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_err_seen && rsp_valid_o) |-> (rsp_err_o && rsp_rdata_o == 32'b0));

  assert_bad_size_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_size_i == 2'd3) |=> (!mem_valid_o && rsp_valid_o && rsp_err_o));

  assert_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || mem_valid_o) |-> !req_ready_o);

  assert_rsp_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_err_o)));

  assert_mem_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_size_o) &&
                                       $stable(mem_write_o) && $stable(mem_wdata_o)));

  logic unused_in;
  assign unused_in = ^{req_write_i, req_addr_i, req_wdata_i, mem_rdata_i};
endmodule

bind bitband_bridge bitband_bridge_chk u_chk (.*);

// File: tb/sim_bitband_bridge.sv
module sim_bitband_bridge;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [31:0] BASE = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        mem_valid, mem_write;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_err = 1'b0;

  always #2.5 clk = ~clk;

  bitband_bridge #(.BASE(BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .rsp_err_o(rsp_err),
    .mem_valid_o(mem_valid), .mem_write_o(mem_write), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_wdata_o(mem_wdata),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // backing memory responder
  logic [7:0]  mem [256];
  int          latency = 0;
  int          wait_cnt = 0;
  int          n_acc = 0;
  int          n_wr = 0;
  bit          hold_bad = 1'b0;
  logic [31:0] first_addr;
  logic [31:0] last_addr;
  logic [1:0]  last_size;
  bit          err_rd_arm = 1'b0;
  bit          err_wr_arm = 1'b0;
  logic [7:0]  err_at = '0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
    forever begin
      @(negedge clk);
      if (mem_valid && !mem_ready) begin
        if (wait_cnt == 0) first_addr = mem_addr;
        else if (mem_addr != first_addr) hold_bad = 1'b1;
        if (wait_cnt < latency) begin
          wait_cnt++;
        end else begin
          wait_cnt  = 0;
          n_acc++;
          last_addr = mem_addr;
          last_size = mem_size;
          mem_ready = 1'b1;
          mem_err   = (mem_write ? err_wr_arm : err_rd_arm) && (mem_addr[7:0] == err_at);
          mem_rdata = {mem[8'(mem_addr + 3)], mem[8'(mem_addr + 2)],
                       mem[8'(mem_addr + 1)], mem[mem_addr[7:0]]};
          if (mem_write) begin
            n_wr++;
            if (!mem_err)
              for (int k = 0; k < (1 << mem_size); k++)
                mem[8'(mem_addr + k)] = mem_wdata[8*k +: 8];
          end
        end
      end else begin
        mem_ready = 1'b0;
        mem_err   = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model from the requirements
  function automatic logic [31:0] ref_addr(input logic [31:0] off, input logic [1:0] sz);
    logic [31:0] a;
    a = BASE | {12'b0, off[24:5]};
    if (sz == 2'd1) a[0] = 1'b0;
    if (sz == 2'd2) a[1:0] = 2'b00;
    return a;
  endfunction

  function automatic int ref_bit(input logic [31:0] off, input logic [1:0] sz);
    return int'(off[6:2]) & ((8 << sz) - 1);
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] w;
    w = '0;
    for (int k = 0; k < (1 << sz); k++) w[8*k +: 8] = mem[8'(a + k)];
    return w;
  endfunction

  bit busy_bad = 1'b0;

  task automatic txn(input bit wr, input logic [1:0] sz, input logic [31:0] off,
                     input logic [31:0] wd, input int hold,
                     output logic [31:0] rd, output logic er);
    logic [31:0] snap_d;
    logic        snap_e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = off; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (hold > 0) rsp_ready = 1'b0;
    while (!rsp_valid) begin
      if (req_ready) busy_bad = 1'b1;
      @(negedge clk);
    end
    snap_d = rsp_rdata; snap_e = rsp_err;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (req_ready || !rsp_valid || rsp_rdata != snap_d || rsp_err != snap_e) busy_bad = 1'b1;
    end
    rsp_ready = 1'b1;
    rd = rsp_rdata; er = rsp_err;
    @(negedge clk);
  endtask

  // {write, size, offset, wdata}
  localparam int NV = 13;
  localparam logic [66:0] VEC [NV] = '{
    {1'b0, 2'd2, 32'h0000_0000, 32'h0},
    {1'b0, 2'd0, 32'h0000_001C, 32'h0},
    {1'b0, 2'd1, 32'h0000_0044, 32'h0},
    {1'b0, 2'd2, 32'h0000_0FFC, 32'h0},
    {1'b1, 2'd0, 32'h0000_0108, 32'h0000_0001},
    {1'b0, 2'd0, 32'h0000_0108, 32'h0},
    {1'b1, 2'd0, 32'h0000_0108, 32'hFFFF_FFFE},
    {1'b0, 2'd0, 32'h0000_0108, 32'h0},
    {1'b1, 2'd2, 32'h0000_0A7C, 32'hFFFF_FFFF},
    {1'b0, 2'd2, 32'h0000_0A7C, 32'h0},
    {1'b1, 2'd1, 32'h0000_0C30, 32'h0000_0001},
    {1'b0, 2'd1, 32'h0000_0C30, 32'h0},
    {1'b0, 2'd0, 32'hFE00_0020, 32'h0}
  };

  initial begin
    logic [31:0] rd, pre, post, exp_w, ea;
    logic        er;
    int          acc0, wr0, b;

    // R10 reset state
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1, "R10", "req_ready in reset", 32'(req_ready), 32'd1);
    chk(!rsp_valid && !mem_valid, "R10", "rsp/mem valid in reset",
        {30'b0, rsp_valid, mem_valid}, 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic        w;
      logic [1:0]  sz;
      logic [31:0] off, wd;
      {w, sz, off, wd} = VEC[v];
      ea  = ref_addr(off, sz);
      b   = ref_bit(off, sz);
      pre = mem_word(ea, sz);
      acc0 = n_acc; wr0 = n_wr;
      txn(w, sz, off, wd, 0, rd, er);
      chk(last_addr == ea, "R1", $sformatf("vec %0d backing addr", v), last_addr, ea);
      chk(last_size == sz, "R2", $sformatf("vec %0d backing size", v), 32'(last_size), 32'(sz));
      chk(er == 1'b0, "R4", $sformatf("vec %0d no error", v), 32'(er), 32'd0);
      if (!w) begin
        chk(rd == {31'b0, pre[b]}, "R3", $sformatf("vec %0d read bit", v), rd, {31'b0, pre[b]});
        chk(n_acc - acc0 == 1 && n_wr == wr0, "R4", $sformatf("vec %0d single read", v),
            32'(n_acc - acc0), 32'd1);
      end else begin
        exp_w = pre;
        exp_w[b] = wd[0];
        post = mem_word(ea, sz);
        chk(post == exp_w, "R5", $sformatf("vec %0d modified data", v), post, exp_w);
        chk(n_wr - wr0 == 1 && n_acc - acc0 == 2, "R5", $sformatf("vec %0d read+write", v),
            32'(n_acc - acc0), 32'd2);
      end
    end

    // R8 illegal size
    acc0 = n_acc;
    txn(1'b0, 2'd3, 32'h0000_0040, 32'h0, 0, rd, er);
    chk(er == 1'b1, "R8", "illegal size error", 32'(er), 32'd1);
    chk(n_acc == acc0, "R8", "no backing access", 32'(n_acc - acc0), 32'd0);

    // R6 read error on alias read
    err_at = 8'h05; err_rd_arm = 1'b1;
    for (int i = 0; i < 8; i++) mem[5][i] = 1'b1;
    txn(1'b0, 2'd0, 32'h0000_00A0, 32'h0, 0, rd, er);
    chk(er == 1'b1 && rd == 32'h0, "R6", "read error on read", {rd[30:0], er}, 32'd1);

    // R6 read error on alias write: no write, memory intact
    pre = mem_word(32'h05, 2'd0); wr0 = n_wr;
    txn(1'b1, 2'd0, 32'h0000_00A4, 32'h0, 0, rd, er);
    post = mem_word(32'h05, 2'd0);
    chk(er == 1'b1, "R6", "error on write's read", 32'(er), 32'd1);
    chk(n_wr == wr0 && post == pre, "R6", "write suppressed", post, pre);
    err_rd_arm = 1'b0;

    // R7 write error
    err_wr_arm = 1'b1;
    txn(1'b1, 2'd0, 32'h0000_00A4, 32'h0, 0, rd, er);
    chk(er == 1'b1, "R7", "backing write error", 32'(er), 32'd1);
    err_wr_arm = 1'b0;

    // R9 response back-pressure and R11 backing wait states
    latency = 3; busy_bad = 1'b0; hold_bad = 1'b0;
    pre = mem_word(32'h30, 2'd2);
    txn(1'b1, 2'd2, 32'h0000_0600, 32'h0000_0001, 4, rd, er);
    chk(!busy_bad, "R9", "busy and stable while held", 32'(busy_bad), 32'd0);
    chk(!hold_bad, "R11", "backing request stable", 32'(hold_bad), 32'd0);
    exp_w = pre; exp_w[0] = 1'b1;
    post = mem_word(32'h30, 2'd2);
    chk(post == exp_w, "R5", "write under wait states", post, exp_w);
    txn(1'b0, 2'd2, 32'h0000_0600, 32'h0, 2, rd, er);
    chk(rd == 32'd1 && !er, "R4", "read back under wait states", rd, 32'd1);
    latency = 0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule